// File: doc/BRIEF.md
# Serial Meggitt Decoder for a Single-Error Cyclic Code

This block corrects one bit error in a word of a cyclic code that is received one bit per clock. The default build is the length-15 Hamming code with 11 data bits and generator g(x) = x^4 + x + 1. Bits arrive highest-order first. While they arrive, they fill a word buffer, and a four-stage polynomial divider builds the remainder (syndrome) of the word modulo g(x).

Once the last bit has been taken, the block streams the word back out, highest-order bit first, over N clocks. In that time the divider runs on its own, which multiplies the syndrome by x once per clock. A single comparator watches the divider for the one syndrome that belongs to an error in the top position. The cyclic shift brings each error position to the top position in turn, so one comparator is enough to flip the erroneous bit at the moment it leaves the buffer. A table of error patterns is therefore not needed.

After the last output bit, a one-cycle pulse marks the end of the word. Two flags go with it: one says a bit was inverted, and the other says the syndrome was nonzero but no inversion happened.

Top module: `meggitt_decoder`

## Requirements
- R1: After reset the block is in the fill state: `in_ready`=1, `out_valid`=0, `word_done`=0, `corrected`=0, `uncorrectable`=0.
- R2: In the fill state a bit is taken only on a clock where `in_valid`=1. Bits arrive highest-order first, and idle cycles between bits are allowed and change nothing.
- R3: The clock after the N-th bit is taken, `out_valid` goes high. It stays high for exactly N consecutive clocks, and `in_ready` is low for that whole time.
- R4: On output cycle k (k=0 first), `out_bit` carries received bit N-1-k. A word with zero syndrome comes out unchanged.
- R5: A single error at any position p (0..N-1) is corrected. The comparator pattern is x^(N-1) mod g(x), which is 1001 (coefficients of x^3..x^0) for the default code.
- R6: When a bit is inverted, the divider clears. At most one bit per word is inverted.
- R7: While `out_valid`=1, `in_valid` and `in_bit` have no effect on the output word or on the flags.
- R8: `word_done` is a one-clock pulse in the clock after the last output bit. `corrected` and `uncorrectable` are updated at the same edge and held until the next `word_done`.
- R9: `uncorrectable`=1 only when the syndrome was nonzero and no bit was inverted. With the default code every nonzero syndrome maps to a position, so a double error gives `corrected`=1 and `uncorrectable`=0.
- R10: A word that follows straight after another one is decoded with no carry-over of syndrome from the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received bit is present on `in_bit` |
| in_bit | input | 1 | Received serial bit, highest-order first |
| in_ready | output | 1 | High while the block takes input bits |
| out_valid | output | 1 | A decoded bit is present on `out_bit` |
| out_bit | output | 1 | Decoded serial bit, highest-order first |
| word_done | output | 1 | One-clock pulse after the last decoded bit |
| corrected | output | 1 | A bit of the last word was inverted |
| uncorrectable | output | 1 | Nonzero syndrome with no inversion in the last word |

## Verification
The bench builds the block with its default parameters: N=15, a four-stage divider, and feedback taps 0011. With these values the bench can sweep an error exhaustively through all fifteen positions. Because the code is perfect, every nonzero syndrome is also reached. The expected output comes from a separate table-style model in the bench, which looks up the error position for each syndrome, so a double error must produce the predicted miscorrection. Input gaps, garbage input during output, and words sent back to back test the sequencing around the comparator.

// File: rtl/meg_pkg.sv
// Package: shared types for the serial cyclic decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package meg_pkg;
    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } meg_phase_e;
endpackage

// File: rtl/meg_syndrome.sv
// Module: syndrome divider and top-position pattern detector.
// Divides the serial input by g(x) (input step) or multiplies the held
// remainder by x (free step). hit_o flags the remainder x^(N-1) mod g.
// Assumes: RW >= 2 and GTAPS holds g(x) without its x^RW term, with bit 0 set.
module meg_syndrome #(
    parameter int          NW    = 15,
    parameter int          RW    = 4,
    parameter logic [RW-1:0] GTAPS = 4'b0011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_in_i,
    input  logic          data_i,
    input  logic          step_free_i,
    input  logic          clear_i,
    output logic [RW-1:0] syn_o,
    output logic          hit_o
);
    // Multiply a remainder by x, modulo g(x).
    function automatic logic [RW-1:0] mul_x(input logic [RW-1:0] s);
        return {s[RW-2:0], 1'b0} ^ (s[RW-1] ? GTAPS : '0);
    endfunction

    // Remainder of x^k modulo g(x).
    function automatic logic [RW-1:0] pow_x(input int k);
        logic [RW-1:0] s;
        s = {{(RW-1){1'b0}}, 1'b1};
        for (int i = 0; i < k; i++) s = mul_x(s);
        return s;
    endfunction

    localparam logic [RW-1:0] TOP_PATTERN = pow_x(NW - 1);

    logic [RW-1:0] syn_q;

    // Purpose: hold, clear, divide-in or free-run the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)           syn_q <= '0;
        else if (clear_i)     syn_q <= '0;
        else if (step_in_i)   syn_q <= mul_x(syn_q) ^ {{(RW-1){1'b0}}, data_i};
        else if (step_free_i) syn_q <= mul_x(syn_q);
    end

    assign syn_o = syn_q;
    assign hit_o = (syn_q == TOP_PATTERN);

    AST_FREE_KEEPS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_free_i && !clear_i && !step_in_i && syn_q != '0) |=> (syn_q != '0)); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (syn_q == '0)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_in_i && !step_free_i) |=> $stable(syn_q)); // R2
endmodule

// File: rtl/meg_buffer.sv
// Module: N-bit word buffer, shifted toward the MSB, top bit exposed.
// Assumes: the caller shifts in zeros while draining.
module meg_buffer #(
    parameter int NW = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic data_i,
    output logic msb_o
);
    logic [NW-1:0] word_q;

    // Purpose: shift one bit in at the LSB end on each shift request.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (shift_i) word_q <= {word_q[NW-2:0], data_i};
    end

    assign msb_o = word_q[NW-1];
endmodule

// File: rtl/meg_ctrl.sv
// Module: phase sequencer and per-word result flags.
// Counts N accepted bits in fill, then N cycles in drain; raises the
// end-of-word pulse and latches the correction and failure flags.
// Assumes: hit_i and syn_nz_i describe the divider in the current cycle.
module meg_ctrl
    import meg_pkg::*;
#(
    parameter int NW = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid_i,
    input  logic hit_i,
    input  logic syn_nz_i,
    output logic fill_o,
    output logic drain_o,
    output logic last_o,
    output logic done_o,
    output logic corr_o,
    output logic unc_o
);
    localparam int CW = (NW > 2) ? $clog2(NW) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(NW - 1);

    meg_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          acc_q;
    logic          done_q, corr_q, unc_q;

    assign fill_o  = (phase_q == PH_FILL);
    assign drain_o = (phase_q == PH_DRAIN);
    assign last_o  = drain_o && (cnt_q == CNT_LAST);

    // Purpose: advance the phase, count bits and latch per-word flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FILL;
            cnt_q   <= '0;
            acc_q   <= 1'b0;
            done_q  <= 1'b0;
            corr_q  <= 1'b0;
            unc_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q == PH_FILL) begin
                if (in_valid_i) begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q   <= '0;
                        phase_q <= PH_DRAIN;
                        acc_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end else begin
                acc_q <= acc_q | hit_i;
                if (cnt_q == CNT_LAST) begin
                    cnt_q   <= '0;
                    phase_q <= PH_FILL;
                    done_q  <= 1'b1;
                    corr_q  <= acc_q | hit_i;
                    unc_q   <= !(acc_q | hit_i) && syn_nz_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign corr_o = corr_q;
    assign unc_o  = unc_q;

    AST_DRAIN_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_o) |-> $past(in_valid_i)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_q && unc_q)); // R9
endmodule

// File: rtl/meggitt_decoder.sv
// Module: serial single-error cyclic decoder (top).
// Fills a buffer and a syndrome divider from a serial word, then drains
// the buffer while the divider free-runs; the top-position pattern
// inverts the bit leaving the buffer and clears the divider.
// Assumes: g(x) has a nonzero constant term and generates a cyclic code of length NW.
module meggitt_decoder #(
    parameter int            NW    = 15,
    parameter int            RW    = 4,
    parameter logic [RW-1:0] GTAPS = 4'b0011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    output logic word_done,
    output logic corrected,
    output logic uncorrectable
);
    logic          fill, drain, last, hit, msb, accept;
    logic [RW-1:0] syn;

    assign accept = fill && in_valid;

    meg_ctrl #(.NW(NW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .hit_i      (drain && hit),
        .syn_nz_i   (syn != '0),
        .fill_o     (fill),
        .drain_o    (drain),
        .last_o     (last),
        .done_o     (word_done),
        .corr_o     (corrected),
        .unc_o      (uncorrectable)
    );

    meg_syndrome #(.NW(NW), .RW(RW), .GTAPS(GTAPS)) u_syn (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_in_i   (accept),
        .data_i      (in_bit),
        .step_free_i (drain && !hit && !last),
        .clear_i     (drain && (hit || last)),
        .syn_o       (syn),
        .hit_o       (hit)
    );

    meg_buffer #(.NW(NW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (accept || drain),
        .data_i  (accept && in_bit),
        .msb_o   (msb)
    );

    assign in_ready  = fill;
    assign out_valid = drain;
    assign out_bit   = drain && (msb ^ hit);

    AST_DONE_AFTER_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> $past(out_valid)); // R8
    AST_FILL_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && last) |=> (syn == '0)); // R10
endmodule

// File: tb/sim_meggitt_decoder.sv
// Bench: directed scenarios for the serial cyclic decoder, one task each.
module sim_meggitt_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, out_valid, out_bit, word_done, corrected, uncorrectable;
    int   checks = 0;
    int   failures = 0;

    always #2.5 clk = ~clk;

    meggitt_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
        .word_done(word_done), .corrected(corrected), .uncorrectable(uncorrectable)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Remainder of a 15-bit word modulo x^4+x+1 by long division.
    function automatic logic [3:0] rem15(input logic [14:0] v);
        logic [14:0] t = v;
        for (int i = 14; i >= 4; i--) if (t[i]) t = t ^ (15'b10011 << (i - 4));
        return t[3:0];
    endfunction

    function automatic logic [14:0] encode(input logic [10:0] info);
        logic [14:0] w = {info, 4'b0000};
        return w | {11'b0, rem15(w)};
    endfunction

    // Table-style reference: find position whose single error gives this syndrome.
    function automatic int pos_of(input logic [3:0] s);
        for (int p = 0; p < 15; p++) if (rem15(15'(1) << p) == s) return p;
        return -1;
    endfunction

    task automatic run_word(input logic [14:0] v, input bit gaps, input bit junk, input string req);
        logic [14:0] got = '0;
        logic [14:0] expw = v;
        int          nval = 0;
        bit          expc = 1'b0;
        int          p;
        p = pos_of(rem15(v));
        if (rem15(v) != 4'd0 && p >= 0) begin
            expw = v ^ (15'(1) << p);
            expc = 1'b1;
        end
        for (int i = 14; i >= 0; i--) begin
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk); in_valid = 1'b0; in_bit = ~v[i];
            end
            @(negedge clk);
            if (i == 14) chk(in_ready == 1'b1, {req, " R2 in_ready"}, in_ready, 1);
            in_valid = 1'b1; in_bit = v[i];
        end
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (out_valid) nval++;
            got[14-k] = out_bit;
            if (k == 3) chk(in_ready == 1'b0, {req, " R3 in_ready low"}, in_ready, 0);
            in_valid = junk ? 1'(k % 2) : 1'b0;
            in_bit   = junk ? 1'(k % 3 == 0) : 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(nval == 15 && !out_valid, {req, " R3 out_valid length"}, nval, 15);
        chk(got == expw, {req, " R4/R5 word"}, got, expw);
        chk(word_done == 1'b1, {req, " R8 word_done"}, word_done, 1);
        chk(corrected == expc, {req, " R8 corrected"}, corrected, expc);
        chk(uncorrectable == 1'b0, {req, " R9 uncorrectable"}, uncorrectable, 0);
        @(negedge clk);
        chk(word_done == 1'b0 && corrected == expc, {req, " R8 pulse/hold"}, {word_done, corrected}, {1'b0, expc});
    endtask

    task automatic t_reset;
        chk(in_ready && !out_valid && !word_done && !corrected && !uncorrectable,
            "R1 reset state", {in_ready, out_valid, word_done, corrected, uncorrectable}, 5'b10000);
    endtask

    task automatic t_clean;
        run_word(encode(11'h000), 0, 0, "R4 zero");
        run_word(15'h7FFF, 0, 0, "R4 all-ones");
        run_word(encode(11'h5A3), 0, 0, "R4 clean");
    endtask

    task automatic t_top_pattern;
        chk(rem15(15'h4000) == 4'b1001, "R5 top syndrome", rem15(15'h4000), 4'b1001);
        run_word(encode(11'h2C1) ^ 15'h4000, 0, 0, "R5 bit14");
        run_word(encode(11'h2C1) ^ 15'h2000, 0, 0, "R5 bit13");
        run_word(encode(11'h2C1) ^ 15'h0001, 0, 0, "R5 bit0");
    endtask

    task automatic t_sweep;
        for (int p = 0; p < 15; p++) run_word(encode(11'h6B9) ^ (15'(1) << p), 0, 0, "R5 sweep");
    endtask

    task automatic t_double;
        run_word(encode(11'h135) ^ 15'h4001, 0, 0, "R6 R9 double");
    endtask

    task automatic t_junk;
        run_word(encode(11'h3F0) ^ 15'h0100, 0, 1, "R7 junk");
        run_word(encode(11'h0F3), 0, 1, "R7 junk clean");
    endtask

    task automatic t_gaps;
        run_word(encode(11'h44D) ^ 15'h0040, 1, 0, "R2 gaps");
    endtask

    task automatic t_back_to_back;
        run_word(encode(11'h111) ^ 15'h0800, 0, 0, "R10 first");
        run_word(encode(11'h222), 0, 0, "R10 second");
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_top_pattern();
        t_sweep();
        t_double();
        t_junk();
        t_gaps();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule